// File: doc/BRIEF.md
# Dual-speed 1-Wire slave bit interface

This block is the timing layer at the bottom of a 1-Wire slave. It watches an oversampled, already synchronised copy of the bus line and owns one open-drain pull-down output. It recognises bus resets and answers each one with a presence pulse. It turns the master's write time slots into single received bits. In read slots it pulls the line low when the bit to send is 0. All bus timing is measured in clock cycles, derived from a clocks-per-microsecond parameter and a set of microsecond parameters.

Standard and overdrive speed run on the same state machine and the same counters. The `od_en` input, driven by the ROM command layer, chooses which set of thresholds applies. Toward that layer the block gives a one-cycle strobe for each received bit and for each reset. It takes a one-cycle load strobe that arms the next time slot as a read slot, and it answers with a done strobe once that slot has been served.

Top module: `onewire_bit_phy`

## Requirements
- R1: After `rst_n` is deasserted, `line_pd` is 0 and `rx_valid`, `tx_done` and `bus_reset` are 0. While the line stays high, none of these outputs is asserted.
- R2: A continuous low on `line_in` that reaches the reset threshold produces exactly one one-cycle `bus_reset` strobe. The threshold is 480 µs at standard speed and 48 µs at overdrive. A write-0 low of 120 µs or less at standard speed produces no strobe.
- R3: A transmit bit armed during a reset low period is discarded by the reset. The next slot is then decoded as a write slot, and no `tx_done` strobe is produced for it.
- R4: After the line returns high following a reset, the block waits and then asserts `line_pd` as a presence pulse. At standard speed the wait lies in 15–60 µs and the pulse in 60–240 µs. At overdrive the wait lies in 2–7 µs and the pulse in 8–26 µs.
- R5: In a slot that was not armed, the block samples the line 30 µs (standard) or 4 µs (overdrive) after the falling edge. It then raises `rx_valid` for one cycle, with `rx_bit` equal to the sampled level, where high means 1. A low of 5–15 µs (standard) or 1–2 µs (overdrive) therefore yields 1, and a low of 60–120 µs (standard) or 7–16 µs (overdrive) yields 0.
- R6: A `tx_load` strobe with `tx_bit` arms the next slot as a read slot. If the bit is 0, `line_pd` is held from the falling edge until about 30 µs (standard) or 4 µs (overdrive) afterwards. If the bit is 1, the line is not driven. The slot ends with a one-cycle `tx_done` strobe and no `rx_valid` strobe.
- R7: `od_en` selects the timing set. A 60 µs low is a bus reset when `od_en` is 1, and a written 0 with no reset when `od_en` is 0.
- R8: A `tx_load` that arrives while a slot is in progress does not change that slot. It arms the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| od_en | input | 1 | 1 selects overdrive timing, 0 selects standard timing |
| line_in | input | 1 | Synchronised bus level, 1 = high |
| line_pd | output | 1 | 1 pulls the bus low through the open-drain driver |
| rx_valid | output | 1 | One-cycle strobe: a written bit was decoded |
| rx_bit | output | 1 | Decoded bit, valid with `rx_valid` |
| tx_load | input | 1 | One-cycle strobe: arm the next slot as a read slot |
| tx_bit | input | 1 | Bit to send, taken with `tx_load` |
| tx_done | output | 1 | One-cycle strobe: the armed read slot was served |
| bus_reset | output | 1 | One-cycle strobe: a bus reset was detected |

## Verification
The bench checks the presence wait and pulse width against the allowed windows at both speeds. A design whose counters used the wrong speed set, or that started counting from the wrong edge, would land outside those windows. It drives 60 µs lows at both speeds: a design that shared one reset threshold would call the standard-speed low a reset, or would miss the overdrive reset. It loads a transmit bit in the middle of a slot and in the middle of a reset low. Logic that applied the bit at once would drive the line in the wrong slot, and logic that let the bit survive the reset would hold the line low in the next slot. Randomised write-slot lows near both ends of their ranges expose a misplaced sampling point, which would return the wrong bit.

// File: rtl/onewire_bit_phy.sv
module onewire_bit_phy #(
  parameter int CLKS_PER_US = 8,
  parameter int RST_STD_US  = 480,
  parameter int RST_OD_US   = 48,
  parameter int PDW_STD_US  = 30,
  parameter int PDW_OD_US   = 3,
  parameter int PDL_STD_US  = 120,
  parameter int PDL_OD_US   = 12,
  parameter int SMP_STD_US  = 30,
  parameter int SMP_OD_US   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic od_en,
  input  logic line_in,
  output logic line_pd,
  output logic rx_valid,
  output logic rx_bit,
  input  logic tx_load,
  input  logic tx_bit,
  output logic tx_done,
  output logic bus_reset
);

  localparam int RST_STD = RST_STD_US * CLKS_PER_US;
  localparam int RST_OD  = RST_OD_US  * CLKS_PER_US;
  localparam int PDW_STD = PDW_STD_US * CLKS_PER_US;
  localparam int PDW_OD  = PDW_OD_US  * CLKS_PER_US;
  localparam int PDL_STD = PDL_STD_US * CLKS_PER_US;
  localparam int PDL_OD  = PDL_OD_US  * CLKS_PER_US;
  localparam int SMP_STD = SMP_STD_US * CLKS_PER_US;
  localparam int SMP_OD  = SMP_OD_US  * CLKS_PER_US;
  localparam int CW      = $clog2(RST_STD + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_SLOT, S_WAITHI, S_RSTHI, S_PDWAIT, S_PDDRV
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lowcnt;
  logic          armed, abit, rd_slot;

  wire [CW-1:0] rst_last = od_en ? CW'(RST_OD - 1) : CW'(RST_STD - 1);
  wire [CW-1:0] smp_last = od_en ? CW'(SMP_OD)     : CW'(SMP_STD);
  wire [CW-1:0] pdw_last = od_en ? CW'(PDW_OD)     : CW'(PDW_STD);
  wire [CW-1:0] pdl_last = od_en ? CW'(PDL_OD)     : CW'(PDL_STD);

  wire rst_hit = !line_in && (lowcnt == rst_last) && (st != S_PDDRV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lowcnt <= '0;
    else if (line_in)
      lowcnt <= '0;
    else if (lowcnt != CW'(RST_STD))
      lowcnt <= lowcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      line_pd   <= 1'b0;
      rx_valid  <= 1'b0;
      rx_bit    <= 1'b0;
      tx_done   <= 1'b0;
      bus_reset <= 1'b0;
      armed     <= 1'b0;
      abit      <= 1'b1;
      rd_slot   <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      tx_done   <= 1'b0;
      bus_reset <= 1'b0;
      case (st)
        S_IDLE: if (!line_in) begin
          st      <= S_SLOT;
          cnt     <= CW'(1);
          rd_slot <= armed;
          line_pd <= armed && !abit;
          armed   <= 1'b0;
        end
        S_SLOT: begin
          if (cnt == smp_last) begin
            st <= S_WAITHI;
            if (rd_slot) begin
              tx_done <= 1'b1;
              line_pd <= 1'b0;
            end else begin
              rx_valid <= 1'b1;
              rx_bit   <= line_in;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAITHI: if (line_in) st <= S_IDLE;
        S_RSTHI: if (line_in) begin
          st  <= S_PDWAIT;
          cnt <= CW'(1);
        end
        S_PDWAIT: begin
          if (cnt == pdw_last) begin
            st      <= S_PDDRV;
            line_pd <= 1'b1;
            cnt     <= CW'(1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PDDRV: begin
          if (cnt == pdl_last) begin
            st      <= S_WAITHI;
            line_pd <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (tx_load) begin
        armed <= 1'b1;
        abit  <= tx_bit;
      end
      if (rst_hit) begin
        st        <= S_RSTHI;
        cnt       <= '0;
        line_pd   <= 1'b0;
        bus_reset <= 1'b1;
        armed     <= 1'b0;
        rd_slot   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/onewire_bit_phy_chk.sv
module onewire_bit_phy_chk (
  input logic clk,
  input logic rst_n,
  input logic line_in,
  input logic line_pd,
  input logic rx_valid,
  input logic tx_done,
  input logic bus_reset
);

  a_r2_reset_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> $past(!line_in));

  a_r2_reset_releases_line: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> !line_pd);

  a_r2_reset_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);

  a_r6_done_releases_line: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !line_pd);

  a_r6_read_slot_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && tx_done));

  a_r5_rx_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

bind onewire_bit_phy onewire_bit_phy_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_pd(line_pd),
  .rx_valid(rx_valid), .tx_done(tx_done), .bus_reset(bus_reset)
);

// File: tb/tb_onewire_bit_phy.sv
`timescale 1ns/1ps
module tb_onewire_bit_phy;
  localparam int CPU = 2;

  logic clk = 1'b0, rst_n = 1'b0, od_en = 1'b0, m_low = 1'b0;
  logic tx_load = 1'b0, tx_bit = 1'b0;
  logic line_pd, rx_valid, rx_bit, tx_done, bus_reset;
  wire  line_in = !(m_low | line_pd);

  always #2.5 clk = ~clk;

  onewire_bit_phy #(.CLKS_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .od_en(od_en), .line_in(line_in),
    .line_pd(line_pd), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .tx_load(tx_load), .tx_bit(tx_bit), .tx_done(tx_done),
    .bus_reset(bus_reset)
  );

  int n_chk = 0, n_fail = 0, rx_n = 0, tx_n = 0, rs_n = 0;
  logic rx_last = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rx_valid) begin rx_n++; rx_last = rx_bit; end
    if (tx_done) tx_n++;
    if (bus_reset) rs_n++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(int u);
    repeat (u * CPU) @(negedge clk);
  endtask

  task automatic pulse_tx(bit b);
    tx_bit = b; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  function automatic int low_us(bit b, bit od);
    if (od) return b ? 1 + int'($urandom % 2) : 7 + int'($urandom % 10);
    return b ? 5 + int'($urandom % 11) : 60 + int'($urandom % 61);
  endfunction

  function automatic int high_us(int lo, bit od);
    int mn = od ? ((9 - lo > 2) ? 9 - lo : 2) : ((65 - lo > 5) ? 65 - lo : 5);
    return mn + 1 + int'($urandom % 5);
  endfunction

  task automatic do_reset(int lo, int arm_at, string tag);
    int r0 = rs_n;
    int w = 0, l = 0;
    m_low = 1'b1;
    if (arm_at >= 0) begin
      wait_us(arm_at);
      pulse_tx(1'b0);
      wait_us(lo - arm_at - 1);
    end else begin
      wait_us(lo);
    end
    m_low = 1'b0;
    chk(rs_n == r0 + 1, {tag, " R2 reset strobe count"}, rs_n - r0, 1);
    while (!line_pd && w < 1000 * CPU) begin @(negedge clk); w++; end
    while (line_pd && l < 1000 * CPU) begin @(negedge clk); l++; end
    if (od_en) begin
      chk(w >= 2 * CPU && w <= 7 * CPU, {tag, " R4 od presence wait"}, w, 4 * CPU);
      chk(l >= 8 * CPU && l <= 26 * CPU, {tag, " R4 od presence width"}, l, 12 * CPU);
    end else begin
      chk(w >= 15 * CPU && w <= 60 * CPU, {tag, " R4 std presence wait"}, w, 30 * CPU);
      chk(l >= 60 * CPU && l <= 240 * CPU, {tag, " R4 std presence width"}, l, 120 * CPU);
    end
    wait_us(10);
  endtask

  task automatic wr_slot(bit b);
    int lo = low_us(b, od_en);
    int hi = high_us(lo, od_en);
    int r0 = rx_n, s0 = rs_n, t0 = tx_n;
    m_low = 1'b1; wait_us(lo);
    m_low = 1'b0; wait_us(hi);
    chk(rx_n == r0 + 1 && tx_n == t0, "R5 one rx strobe per write slot", rx_n - r0, 1);
    chk(rx_last == b, "R5 decoded bit", int'(rx_last), int'(b));
    chk(rs_n == s0, "R2 write low is not a reset", rs_n - s0, 0);
  endtask

  task automatic rd_slot(bit b);
    int r0 = rx_n, t0 = tx_n;
    logic v;
    pulse_tx(b);
    m_low = 1'b1; wait_us(od_en ? 1 : 3);
    m_low = 1'b0; wait_us(od_en ? 1 : 12);
    v = line_in;
    wait_us(od_en ? 10 : 60);
    chk(v == b, "R6 read slot line level", int'(v), int'(b));
    chk(tx_n == t0 + 1 && rx_n == r0, "R6 tx_done without rx", tx_n - t0, 1);
  endtask

  initial begin
    int r0, t0, s0;
    logic v;
    void'($urandom(32'd90125));
    repeat (4) @(negedge clk);
    chk(line_pd == 1'b0, "R1 line released in reset", int'(line_pd), 0);
    chk({rx_valid, tx_done, bus_reset} == 3'b0, "R1 strobes low in reset",
        int'({rx_valid, tx_done, bus_reset}), 0);
    rst_n = 1'b1;
    s0 = rs_n; r0 = rx_n;
    wait_us(20);
    chk(rs_n == s0 && rx_n == r0 && !line_pd, "R1 idle line is quiet", rs_n + rx_n - s0 - r0, 0);

    do_reset(500, -1, "std");
    for (int i = 0; i < 24; i++) begin
      if ($urandom % 2) wr_slot(1'($urandom)); else rd_slot(1'($urandom));
    end

    // R7: 60 us low at standard speed is a written 0
    r0 = rx_n; s0 = rs_n;
    m_low = 1'b1; wait_us(60); m_low = 1'b0; wait_us(10);
    chk(rs_n == s0, "R7 std 60us low not reset", rs_n - s0, 0);
    chk(rx_n == r0 + 1 && rx_last == 1'b0, "R7 std 60us low reads 0", int'(rx_last), 0);

    // R8: load during a slot arms the next one
    r0 = rx_n; t0 = tx_n;
    m_low = 1'b1; wait_us(10); pulse_tx(1'b0); wait_us(60);
    m_low = 1'b0; wait_us(10);
    chk(rx_n == r0 + 1 && rx_last == 1'b0 && tx_n == t0, "R8 current slot unchanged",
        tx_n - t0, 0);
    m_low = 1'b1; wait_us(3); m_low = 1'b0; wait_us(12);
    v = line_in;
    wait_us(60);
    chk(v == 1'b0, "R8 next slot driven 0", int'(v), 0);
    chk(tx_n == t0 + 1, "R8 next slot tx_done", tx_n - t0, 1);

    // R3: bit armed during reset low is dropped
    do_reset(500, 100, "R3");
    r0 = rx_n; t0 = tx_n;
    m_low = 1'b1; wait_us(3); m_low = 1'b0; wait_us(12);
    v = line_in;
    wait_us(60);
    chk(v == 1'b1, "R3 line not driven after reset", int'(v), 1);
    chk(tx_n == t0 && rx_n == r0 + 1 && rx_last == 1'b1, "R3 slot decoded as write 1",
        tx_n - t0, 0);

    // overdrive: R7 60 us low is a reset
    od_en = 1'b1;
    do_reset(60, -1, "R7 od");
    for (int i = 0; i < 24; i++) begin
      if ($urandom % 2) wr_slot(1'($urandom)); else rd_slot(1'($urandom));
    end
    wr_slot(1'b0);
    wr_slot(1'b1);

    od_en = 1'b0;
    do_reset(600, -1, "std long");
    wr_slot(1'b1);
    rd_slot(1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule